// File: doc/BRIEF.md
# I2C Byte-Completion Flag and Clock-Stretch Controller

This block keeps the per-byte completion flag of an I2C controller. A separate bit/byte engine sends it two strobes: one when the eight data bits of a byte have moved, and one when the acknowledge slot has finished. When a byte ends and the controller is involved in the transfer, the flag sets. The controller is involved when it is bus master, when it is addressed as a slave, when it received a general call, or when it lost arbitration.

While the flag is up, the block asks the bus engine to hold SCL low, and it raises an interrupt if the interrupt is enabled. Software lets the next byte proceed by writing 0 to the flag. Commanding a repeated start or a stop as master also clears the flag.

A mode bit chooses whether the flag sets on received data bytes before or after the acknowledge. The block also decodes the start and stop command bits of the control register into one-cycle request pulses to the bus engine.

Top module: `i2c_xfer_flag`

## Requirements
- R1: `o_irq` is 1 exactly when the flag (control bit 0) and the interrupt enable (control bit 1) are both 1.
- R2: The flag sets at the end of a byte only when at least one of `i_master`, `i_addressed`, `i_gencall` or `i_arb_lost` is 1. A byte-end strobe with all four low leaves the flag at 0.
- R3: When the ack-timing bit (control bit 4) is 1 and `i_rx_data` is 1, the flag sets on `i_bits_done`. In every other case it sets on `i_ack_done`, and `i_bits_done` has no effect.
- R4: A write with control bit 0 equal to 0 clears the flag. A write with bit 0 equal to 1 leaves the flag unchanged.
- R5: When `i_master` is 1, a write of 1 to the start bit (control bit 2) clears the flag. A write of 0 to the master-select bit (control bit 3) while that bit holds 1 also clears the flag. When `i_master` is 0, neither write touches the flag.
- R6: `o_scl_hold` is 1 exactly while the flag is 1. Clearing the flag drops the hold in the same cycle that the flag falls.
- R7: A read with `rd_rmw` set returns 1 in bit 0 whatever the flag holds. A plain read returns the true flag. Bits 1, 3 and 4 read back the stored enable, master-select and ack-timing values. Bit 2 and bits 7..5 read 0.
- R8: An accepted write with the start bit 1 produces a one-cycle `o_start_req` pulse in the following cycle, whatever the flag holds. An accepted write that changes master-select from 1 to 0 produces a one-cycle `o_stop_req` pulse in the following cycle.
- R9: While `i_en` is 0 or `i_bus_err` is 1, the flag, the interrupt enable, the master-select and the ack-timing bits are forced to 0, and writes are ignored.
- R10: When a set event and a clearing write fall in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_en | input | 1 | Module enable |
| i_bus_err | input | 1 | Bus error flagged |
| i_bits_done | input | 1 | Strobe: eight data bits of a byte finished |
| i_ack_done | input | 1 | Strobe: acknowledge slot finished |
| i_rx_data | input | 1 | Current byte is a received data byte |
| i_master | input | 1 | Controller is bus master |
| i_addressed | input | 1 | Addressed as slave |
| i_gencall | input | 1 | General call received |
| i_arb_lost | input | 1 | Arbitration lost |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | DATA_W | Control register write data |
| rd_en | input | 1 | Control register read strobe |
| rd_rmw | input | 1 | Read belongs to a read-modify-write |
| rd_data | output | DATA_W | Control register read data |
| o_irq | output | 1 | Completion interrupt request |
| o_scl_hold | output | 1 | Request to hold SCL low |
| o_start_req | output | 1 | Start / repeated-start request pulse |
| o_stop_req | output | 1 | Stop request pulse |

## Verification
Byte completion and the software clear can land in the same clock. The bench provokes this by asserting an acknowledge-done strobe, with master mode active, in the same cycle as a write of 0 to the flag. The flag must read 1 afterwards, so the completion is not lost.

Command decoding and flag clearing also share a cycle. A start write in master mode must clear the flag and pulse the start request together. The same write outside master mode must pulse the request and leave the flag untouched.

// File: rtl/i2c_xfer_flag_pkg.sv
package i2c_xfer_flag_pkg;
  // Control register field positions
  localparam int FLAG_B   = 0;
  localparam int IE_B     = 1;
  localparam int START_B  = 2;
  localparam int MSEL_B   = 3;
  localparam int ACKSEL_B = 4;
  localparam int MIN_W    = 5;

  // Controller takes part in the transfer
  function automatic logic involved(input logic m, input logic a,
                                    input logic g, input logic l);
    return m | a | g | l;
  endfunction

  // Flag sets before the acknowledge slot
  function automatic logic early_point(input logic acksel, input logic rx);
    return acksel & rx;
  endfunction

  // Byte-end strobe that counts for the current mode
  function automatic logic byte_end(input logic acksel, input logic rx,
                                    input logic bits_done, input logic ack_done);
    return early_point(acksel, rx) ? bits_done : ack_done;
  endfunction
endpackage

// File: rtl/i2c_xfer_ctrl.sv
module i2c_xfer_ctrl
  import i2c_xfer_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_acc,
  output logic              ie_q,
  output logic              msel_q,
  output logic              acksel_q,
  output logic              start_cmd,
  output logic              stop_cmd,
  output logic              start_req,
  output logic              stop_req
);
  assign wr_acc    = wr_en & ~clr_all;
  assign start_cmd = wr_acc & wr_data[START_B];
  assign stop_cmd  = wr_acc & msel_q & ~wr_data[MSEL_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q     <= 1'b0;
      msel_q   <= 1'b0;
      acksel_q <= 1'b0;
    end else if (clr_all) begin
      ie_q     <= 1'b0;
      msel_q   <= 1'b0;
      acksel_q <= 1'b0;
    end else if (wr_acc) begin
      ie_q     <= wr_data[IE_B];
      msel_q   <= wr_data[MSEL_B];
      acksel_q <= wr_data[ACKSEL_B];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_req <= 1'b0;
      stop_req  <= 1'b0;
    end else begin
      start_req <= start_cmd;
      stop_req  <= stop_cmd;
    end
  end

  a_r8_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd |=> start_req);
  a_r8_stop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> stop_req);
  a_r9_ctrl_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (!ie_q && !msel_q && !acksel_q));
endmodule

// File: rtl/i2c_xfer_flagcore.sv
module i2c_xfer_flagcore
  import i2c_xfer_flag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_all,
  input  logic bits_done,
  input  logic ack_done,
  input  logic rx_data,
  input  logic acksel,
  input  logic m_mode,
  input  logic addressed,
  input  logic gencall,
  input  logic arb_lost,
  input  logic wr_acc,
  input  logic wr_flag_bit,
  input  logic cmd_clr,
  output logic set_evt,
  output logic flag_q
);
  assign set_evt = involved(m_mode, addressed, gencall, arb_lost) &
                   byte_end(acksel, rx_data, bits_done, ack_done);

  logic sw_clr;
  assign sw_clr = wr_acc & ~wr_flag_bit;

  // Priority: disable/bus error, then set event, then command or software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (clr_all) flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (cmd_clr) flag_q <= 1'b0;
    else if (sw_clr)  flag_q <= 1'b0;
  end

  a_r2_set_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && !clr_all) |=> flag_q);
  a_r4_write_one_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && wr_flag_bit && !set_evt && !flag_q) |=> !flag_q);
  a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && sw_clr && !clr_all) |=> flag_q);
  a_r9_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> !flag_q);
endmodule

// File: rtl/i2c_xfer_flag.sv
module i2c_xfer_flag
  import i2c_xfer_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_en,
  input  logic              i_bus_err,
  input  logic              i_bits_done,
  input  logic              i_ack_done,
  input  logic              i_rx_data,
  input  logic              i_master,
  input  logic              i_addressed,
  input  logic              i_gencall,
  input  logic              i_arb_lost,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_rmw,
  output logic [DATA_W-1:0] rd_data,
  output logic              o_irq,
  output logic              o_scl_hold,
  output logic              o_start_req,
  output logic              o_stop_req
);
  initial begin
    if (DATA_W < MIN_W) $error("DATA_W too small for control fields");
  end

  logic clr_all, wr_acc, ie_q, msel_q, acksel_q;
  logic start_cmd, stop_cmd, cmd_clr, set_evt, flag_q;

  assign clr_all = ~i_en | i_bus_err;
  assign cmd_clr = i_master & (start_cmd | stop_cmd);

  i2c_xfer_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
    .wr_en(wr_en), .wr_data(wr_data), .wr_acc(wr_acc),
    .ie_q(ie_q), .msel_q(msel_q), .acksel_q(acksel_q),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .start_req(o_start_req), .stop_req(o_stop_req)
  );

  i2c_xfer_flagcore u_flag (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
    .bits_done(i_bits_done), .ack_done(i_ack_done), .rx_data(i_rx_data),
    .acksel(acksel_q), .m_mode(i_master), .addressed(i_addressed),
    .gencall(i_gencall), .arb_lost(i_arb_lost),
    .wr_acc(wr_acc), .wr_flag_bit(wr_data[FLAG_B]), .cmd_clr(cmd_clr),
    .set_evt(set_evt), .flag_q(flag_q)
  );

  assign o_irq      = flag_q & ie_q;
  assign o_scl_hold = flag_q;

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      rd_data[FLAG_B]   = flag_q | rd_rmw;
      rd_data[IE_B]     = ie_q;
      rd_data[MSEL_B]   = msel_q;
      rd_data[ACKSEL_B] = acksel_q;
    end
  end

  a_r1_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    o_irq |-> (ie_q && o_scl_hold));
  a_r6_hold_while_set: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |-> o_scl_hold);
  a_r5_cmd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr && !set_evt) |=> !o_scl_hold);
endmodule

// File: tb/tb_i2c_xfer_flag.sv
module tb_i2c_xfer_flag;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic i_en, i_bus_err, i_bits_done, i_ack_done, i_rx_data;
  logic i_master, i_addressed, i_gencall, i_arb_lost;
  logic wr_en, rd_en, rd_rmw;
  logic [W-1:0] wr_data, rd_data;
  logic o_irq, o_scl_hold, o_start_req, o_stop_req;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  i2c_xfer_flag #(.DATA_W(W)) dut (.*);

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bits: 0 flag, 1 ie, 2 start, 3 master-select, 4 ack-timing
  task automatic wr(input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic rmw, output logic [W-1:0] d);
    @(negedge clk); rd_en = 1'b1; rd_rmw = rmw; #1 d = rd_data;
    rd_en = 1'b0; rd_rmw = 1'b0;
  endtask

  task automatic strobe(input logic bits, input logic ack);
    @(negedge clk); i_bits_done = bits; i_ack_done = ack;
    @(negedge clk); i_bits_done = 1'b0; i_ack_done = 1'b0;
  endtask

  task automatic qual(input logic m, input logic a, input logic g, input logic l);
    i_master = m; i_addressed = a; i_gencall = g; i_arb_lost = l;
  endtask

  task automatic t_reset;
    logic [W-1:0] d;
    chk("R6 reset hold", o_scl_hold, 0);
    chk("R1 reset irq", o_irq, 0);
    rd(1'b0, d); chk("R7 reset read", d, 0);
  endtask

  task automatic t_qualify;
    qual(0,0,0,0); strobe(0,1); chk("R2 no qualifier", o_scl_hold, 0);
    qual(0,1,0,0); strobe(0,1); chk("R2 addressed sets", o_scl_hold, 1);
    wr(8'h00); chk("R4 write0 clears", o_scl_hold, 0);
    qual(0,0,0,1); strobe(0,1); chk("R2 arb lost sets", o_scl_hold, 1);
    wr(8'h00);
    qual(0,0,1,0); strobe(0,1); chk("R2 general call sets", o_scl_hold, 1);
    wr(8'h00); qual(0,0,0,0);
  endtask

  task automatic t_irq_write;
    qual(0,1,0,0); strobe(0,1);
    chk("R1 irq without enable", o_irq, 0);
    wr(8'h03); chk("R1 irq with enable", o_irq, 1);
    chk("R4 write1 keeps flag", o_scl_hold, 1);
    wr(8'h02); chk("R4 write0 clears", o_scl_hold, 0);
    chk("R1 irq drops", o_irq, 0);
    wr(8'h03); chk("R4 write1 does not set", o_scl_hold, 0);
    wr(8'h00); qual(0,0,0,0);
  endtask

  task automatic t_ack_timing;
    qual(0,1,0,0);
    i_rx_data = 1'b1; wr(8'h10);
    strobe(1,0); chk("R3 early set on rx data", o_scl_hold, 1);
    wr(8'h10);
    i_rx_data = 1'b0; strobe(1,0); chk("R3 bits_done ignored for tx", o_scl_hold, 0);
    strobe(0,1); chk("R3 ack set for tx", o_scl_hold, 1);
    wr(8'h00); i_rx_data = 1'b1;
    strobe(1,0); chk("R3 bits_done ignored late mode", o_scl_hold, 0);
    strobe(0,1); chk("R3 ack set late mode", o_scl_hold, 1);
    wr(8'h00); i_rx_data = 1'b0; qual(0,0,0,0);
  endtask

  task automatic t_commands;
    logic [W-1:0] d;
    qual(1,0,0,0); wr(8'h08); strobe(0,1);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h0D;
    @(negedge clk); wr_en = 1'b0;
    chk("R8 start pulse", o_start_req, 1);
    chk("R5 repeated start clears", o_scl_hold, 0);
    @(negedge clk); chk("R8 start pulse one cycle", o_start_req, 0);
    strobe(0,1);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h01;
    @(negedge clk); wr_en = 1'b0;
    chk("R8 stop pulse", o_stop_req, 1);
    chk("R5 stop clears", o_scl_hold, 0);
    @(negedge clk); chk("R8 stop pulse one cycle", o_stop_req, 0);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h04;
    @(negedge clk); wr_en = 1'b0;
    chk("R8 start with flag 0", o_start_req, 1);
    qual(0,1,0,0); strobe(0,1);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h05;
    @(negedge clk); wr_en = 1'b0;
    chk("R8 slave start pulse", o_start_req, 1);
    chk("R5 slave start keeps flag", o_scl_hold, 1);
    rd(1'b0, d); chk("R7 plain read", d, 8'h01);
    wr(8'h00);
    rd(1'b1, d); chk("R7 rmw read", d, 8'h01);
    rd(1'b0, d); chk("R7 true flag read", d, 8'h00);
    qual(0,0,0,0);
  endtask

  task automatic t_disable;
    logic [W-1:0] d;
    qual(0,1,0,0); wr(8'h1B); strobe(0,1);
    @(negedge clk); i_en = 1'b0;
    @(negedge clk); chk("R9 disable clears flag", o_scl_hold, 0);
    rd(1'b0, d); chk("R9 disable clears fields", d, 8'h00);
    wr(8'h1A); rd(1'b0, d); chk("R9 write ignored", d, 8'h00);
    i_en = 1'b1; wr(8'h1A); strobe(0,1);
    @(negedge clk); i_bus_err = 1'b1;
    @(negedge clk); i_bus_err = 1'b0;
    rd(1'b0, d); chk("R9 bus error clears", d, 8'h00);
    qual(0,0,0,0);
  endtask

  task automatic t_collide;
    qual(1,0,0,0);
    @(negedge clk); i_ack_done = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
    @(negedge clk); i_ack_done = 1'b0; wr_en = 1'b0;
    chk("R10 set wins over clear", o_scl_hold, 1);
    wr(8'h00); chk("R6 hold released", o_scl_hold, 0);
    qual(0,0,0,0);
  endtask

  initial begin
    i_en = 1; i_bus_err = 0; i_bits_done = 0; i_ack_done = 0; i_rx_data = 0;
    qual(0,0,0,0); wr_en = 0; wr_data = '0; rd_en = 0; rd_rmw = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_qualify();
    t_irq_write();
    t_ack_timing();
    t_commands();
    t_disable();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule